// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a 32-bit watchdog for a register bus. A free-running up-counter is advanced by a prescaled reference tick. When the counter steps past all-ones it wraps to the value held in a load register. At the same moment it raises a one-cycle reset-request pulse and sets a sticky timeout flag. Software keeps the system alive by rewriting the count register before the counter reaches all-ones. A timeout of T seconds at 32768 ticks per second is programmed by loading the two's complement of T times 32768.

The run state cannot be changed by a single stray write. Stopping takes the key word 0x0000AAAA followed by 0x00005555. Starting takes 0x0000BBBB followed by 0x00004444. Both words go to the start/stop register as consecutive accepted bus transactions. The usual flow is to stop the watchdog, program the load and count registers, then send the start sequence.

The bus request channel uses a valid/ready handshake. The block never applies back-pressure: `bus_ready` is held high, so every request with `bus_valid` high is accepted in that cycle. Read data comes back exactly one cycle later on `rsp_valid`/`rsp_data`. There is no ready on the response side, so the requester must always be able to take it.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the watchdog is stopped, the count, load and timeout-flag registers read zero, and `wdt_bite` is low.
- R2: Writing 0x0000BBBB and then 0x00004444 to the start/stop register (byte offset 0x48), as two consecutive accepted transactions, starts the watchdog. Bit 0 of a read of 0x48 returns the run state.
- R3: Writing 0x0000AAAA and then 0x00005555 to offset 0x48, as two consecutive accepted transactions, stops the watchdog.
- R4: In these cases the run state stays as it was: any other accepted transaction falls between the two words, the second word does not match the first, or the second word comes alone. Idle cycles between the words do not break a sequence. A first key word always starts a new sequence.
- R5: While the watchdog runs, the count register (offset 0x28) increases by one on every TICK_DIV-th cycle with `ref_tick` high. While it is stopped, the count holds and the tick divider is cleared.
- R6: A step taken at count all-ones loads the count from the load register (offset 0x2C). It also drives `wdt_bite` high for exactly the next cycle and sets bit 0 of the timeout flag register (offset 0x54).
- R7: Writing a value with bit 0 set to offset 0x54 clears the timeout flag. Writing with bit 0 clear leaves it set. A timeout in the same cycle wins over the clear.
- R8: Writes to the count and load registers take effect at once, whether the watchdog runs or not. A count write wins over a counter step in the same cycle.
- R9: `bus_ready` is always high. An accepted read raises `rsp_valid` for the next cycle only, with the register value from before that cycle's writes. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per tick |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready, always high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_data | output | DATA_W | Read data |
| wdt_bite | output | 1 | One-cycle reset request on timeout |

## Verification
On every cycle, the assertions check four things. A change of run state must be preceded by a start/stop write. A stopped counter holds unless it is written. A running counter steps by exactly one. A reset request only follows a step at all-ones, with the timeout flag set. They also check the one-cycle read response timing. Other behaviours can only be shown by the bench's scenarios against its reference model: the key ordering rules, including idle gaps, restarted and interleaved sequences, and the reload value after a wrap. The same holds for the flag clear priority, write-versus-step priority and unmapped offsets.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] OFS_COUNT = 8'h28;
  localparam logic [7:0] OFS_LOAD  = 8'h2C;
  localparam logic [7:0] OFS_KEY   = 8'h48;
  localparam logic [7:0] OFS_FLAG  = 8'h54;

  localparam logic [31:0] KEY_STOP_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_STOP_B = 32'h0000_5555;
  localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_STOP_HALF = 2'd1,
    SEQ_RUN_HALF  = 2'd2
  } seq_t;

  typedef struct packed {
    logic wr_count;
    logic wr_load;
    logic wr_key;
    logic wr_flag;
    logic other;
  } strobe_t;

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] cur_count,
  input  logic [DATA_W-1:0] cur_load,
  input  logic              cur_run,
  input  logic              cur_flag,
  output strobe_t           stb,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFS_FLAG);

  logic              accept;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_mux;

  assign bus_ready = 1'b1;
  assign accept    = bus_valid && bus_ready;
  assign rd_fire   = accept && !bus_we;

  always_comb begin
    stb          = '0;
    stb.wr_count = accept && bus_we && (bus_addr == A_COUNT);
    stb.wr_load  = accept && bus_we && (bus_addr == A_LOAD);
    stb.wr_key   = accept && bus_we && (bus_addr == A_KEY);
    stb.wr_flag  = accept && bus_we && (bus_addr == A_FLAG);
    stb.other    = accept && !stb.wr_key;
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_COUNT: rd_mux = cur_count;
      A_LOAD:  rd_mux = cur_load;
      A_KEY:   rd_mux = DATA_W'(cur_run);
      A_FLAG:  rd_mux = DATA_W'(cur_flag);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= rd_mux;
    end
  end

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic              other,
  input  logic [DATA_W-1:0] wdata,
  output logic              run
);

  localparam logic [DATA_W-1:0] K_SA = DATA_W'(KEY_STOP_A);
  localparam logic [DATA_W-1:0] K_SB = DATA_W'(KEY_STOP_B);
  localparam logic [DATA_W-1:0] K_RA = DATA_W'(KEY_RUN_A);
  localparam logic [DATA_W-1:0] K_RB = DATA_W'(KEY_RUN_B);

  seq_t seq_q, seq_d;
  logic run_d;

  always_comb begin
    seq_d = seq_q;
    run_d = run;
    if (wr_key) begin
      seq_d = SEQ_IDLE;
      if (wdata == K_SA) begin
        seq_d = SEQ_STOP_HALF;
      end else if (wdata == K_RA) begin
        seq_d = SEQ_RUN_HALF;
      end else if (wdata == K_SB && seq_q == SEQ_STOP_HALF) begin
        run_d = 1'b0;
      end else if (wdata == K_RB && seq_q == SEQ_RUN_HALF) begin
        run_d = 1'b1;
      end
    end else if (other) begin
      seq_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= SEQ_IDLE;
      run   <= 1'b0;
    end else begin
      seq_q <= seq_d;
      run   <= run_d;
    end
  end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_tick,
  output logic step
);

  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign step = run && ref_tick;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] div_q;

      assign step = run && ref_tick && (div_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
          div_q <= '0;
        end else if (ref_tick) begin
          div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_count,
  input  logic              wr_load,
  input  logic              wr_flag,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] load,
  output logic              flag,
  output logic              bite
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic wrap;

  assign wrap = step && !wr_count && (count == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      load  <= '0;
      flag  <= 1'b0;
      bite  <= 1'b0;
    end else begin
      if (wr_count)  count <= wdata;
      else if (wrap) count <= load;
      else if (step) count <= count + 1'b1;

      if (wr_load) load <= wdata;

      if (wrap)                     flag <= 1'b1;
      else if (wr_flag && wdata[0]) flag <= 1'b0;

      bite <= wrap;
    end
  end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wdt_bite
);

  strobe_t           stb;
  logic              run_q;
  logic              step;
  logic              flag_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] load_q;

  wdt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .cur_count (cnt_q),
    .cur_load  (load_q),
    .cur_run   (run_q),
    .cur_flag  (flag_q),
    .stb       (stb),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  wdt_keyseq #(.DATA_W(DATA_W)) u_keyseq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_key (stb.wr_key),
    .other  (stb.other),
    .wdata  (bus_wdata),
    .run    (run_q)
  );

  wdt_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .ref_tick (ref_tick),
    .step     (step)
  );

  wdt_counter #(.DATA_W(DATA_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .wr_count (stb.wr_count),
    .wr_load  (stb.wr_load),
    .wr_flag  (stb.wr_flag),
    .wdata    (bus_wdata),
    .count    (cnt_q),
    .load     (load_q),
    .flag     (flag_q),
    .bite     (wdt_bite)
  );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              run,
  input logic              step,
  input logic [DATA_W-1:0] cnt,
  input logic              flag,
  input logic              bite,
  input logic              rsp_valid
);

  logic wr_cnt_c, wr_key_c, rd_c;

  assign wr_cnt_c = bus_valid && bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_key_c = bus_valid && bus_we && (bus_addr == ADDR_W'(OFS_KEY));
  assign rd_c     = bus_valid && !bus_we;

  p_run_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run != $past(run)) |-> $past(wr_key_c));

  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt_c) |=> (cnt == $past(cnt)));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !wr_cnt_c && (cnt != '1)) |=> (cnt == $past(cnt) + DATA_W'(1)));

  p_bite_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bite |-> ($past(step) && ($past(cnt) == '1)));

  p_bite_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bite |-> flag);

  p_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c |=> rsp_valid);

  p_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_c |=> !rsp_valid);

endmodule

bind wdt_keyed wdt_keyed_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .run       (run_q),
  .step      (step),
  .cnt       (cnt_q),
  .flag      (flag_q),
  .bite      (wdt_bite),
  .rsp_valid (rsp_valid)
);

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;

  localparam int DIV = 2;
  localparam logic [7:0] A_CNT = 8'h28, A_LD = 8'h2C, A_KEY = 8'h48, A_FLG = 8'h54, A_NONE = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        wdt_bite;

  always #2 clk = ~clk;

  wdt_keyed #(.ADDR_W(8), .DATA_W(32), .TICK_DIV(DIV)) i_wdt_keyed (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wdt_bite(wdt_bite)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic        m_run, m_flag, m_bite, m_rv;
  logic [1:0]  m_seq;
  int          m_psc;
  logic [31:0] m_cnt, m_load, m_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_flag = 0; m_bite = 0; m_rv = 0; m_seq = 0;
    m_psc = 0; m_cnt = 0; m_load = 0; m_rd = 0;
  endtask

  task automatic cyc(input logic v, input logic we, input logic [7:0] a,
                     input logic [31:0] d, input logic t);
    logic wc, wl, wk, wf, step, wrap;
    logic [31:0] rdv;
    @(negedge clk);
    bus_valid = v; bus_we = we; bus_addr = a; bus_wdata = d; ref_tick = t;
    wc = v && we && a == A_CNT;
    wl = v && we && a == A_LD;
    wk = v && we && a == A_KEY;
    wf = v && we && a == A_FLG;
    case (a)
      A_CNT: rdv = m_cnt;
      A_LD:  rdv = m_load;
      A_KEY: rdv = {31'd0, m_run};
      A_FLG: rdv = {31'd0, m_flag};
      default: rdv = 32'd0;
    endcase
    step = m_run && t && (m_psc == DIV - 1);
    wrap = step && !wc && (m_cnt == 32'hFFFF_FFFF);
    @(posedge clk);
    #1;
    // apply requirement-level next state
    if (v && !we) m_rd = rdv;
    m_rv = v && !we;
    if (!m_run) m_psc = 0;
    else if (t) m_psc = (m_psc == DIV - 1) ? 0 : m_psc + 1;
    if (wc) m_cnt = d;
    else if (wrap) m_cnt = m_load;
    else if (step) m_cnt = m_cnt + 1;
    if (wl) m_load = d;
    if (wrap) m_flag = 1;
    else if (wf && d[0]) m_flag = 0;
    m_bite = wrap;
    if (wk) begin
      if (d == 32'h0000_AAAA) m_seq = 1;
      else if (d == 32'h0000_BBBB) m_seq = 2;
      else begin
        if (d == 32'h0000_5555 && m_seq == 1) m_run = 0;
        if (d == 32'h0000_4444 && m_seq == 2) m_run = 1;
        m_seq = 0;
      end
    end else if (v) m_seq = 0;
    chk("R9 bus_ready", {31'd0, bus_ready}, 32'd1);
    chk("R9 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
    if (m_rv) chk("R9 rsp_data", rsp_data, m_rd);
    chk("R6 wdt_bite", {31'd0, wdt_bite}, {31'd0, m_bite});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0);
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'd0, t);
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    cyc(1, 0, a, 32'd0, 0);
    chk(tag, rsp_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 bite after reset", {31'd0, wdt_bite}, 32'd0);
    rd_exp(A_CNT, 32'd0, "R1 count");
    rd_exp(A_LD,  32'd0, "R1 load");
    rd_exp(A_KEY, 32'd0, "R1 run state");
    rd_exp(A_FLG, 32'd0, "R1 flag");

    // R5 stopped counter holds
    idle(6, 1);
    rd_exp(A_CNT, 32'd0, "R5 stopped holds");

    // R2 start with idle gap between words
    wr(A_LD, 32'hFFFF_FFF0);
    wr(A_CNT, 32'hFFFF_FFF0);
    wr(A_KEY, 32'h0000_BBBB);
    idle(3, 0);
    wr(A_KEY, 32'h0000_4444);
    rd_exp(A_KEY, 32'd1, "R2 started");

    // R5 counting, divide by 2
    idle(6, 1);
    rd_exp(A_CNT, 32'hFFFF_FFF3, "R5 three steps");

    // R8 count write beats a step
    wr(A_CNT, 32'hFFFF_FFFF);
    idle(1, 1);
    cyc(1, 1, A_CNT, 32'd5, 1);
    rd_exp(A_CNT, 32'd5, "R8 write wins over step");
    wr(A_LD, 32'hFFFF_FFE0);
    rd_exp(A_LD, 32'hFFFF_FFE0, "R8 load write while running");

    // R6 overflow
    wr(A_CNT, 32'hFFFF_FFFF);
    idle(2, 1);
    chk("R6 bite raised", {31'd0, wdt_bite}, 32'd1);
    idle(1, 0);
    chk("R6 bite one cycle", {31'd0, wdt_bite}, 32'd0);
    rd_exp(A_CNT, 32'hFFFF_FFE0, "R6 reload value");
    rd_exp(A_FLG, 32'd1, "R6 flag set");

    // R7 flag clear
    wr(A_FLG, 32'hFFFF_FFFE);
    rd_exp(A_FLG, 32'd1, "R7 bit0 clear keeps flag");
    wr(A_FLG, 32'd1);
    rd_exp(A_FLG, 32'd0, "R7 flag cleared");

    // R4 broken sequences
    wr(A_KEY, 32'h0000_AAAA);
    wr(A_LD, 32'hFFFF_FFF0);
    wr(A_KEY, 32'h0000_5555);
    rd_exp(A_KEY, 32'd1, "R4 interleaved write");
    wr(A_KEY, 32'h0000_AAAA);
    wr(A_KEY, 32'h0000_1234);
    wr(A_KEY, 32'h0000_5555);
    rd_exp(A_KEY, 32'd1, "R4 wrong second word");
    wr(A_KEY, 32'h0000_BBBB);
    wr(A_KEY, 32'h0000_5555);
    rd_exp(A_KEY, 32'd1, "R4 mismatched pair");

    // R3 stop, with restarted first word
    wr(A_KEY, 32'h0000_AAAA);
    wr(A_KEY, 32'h0000_AAAA);
    idle(2, 0);
    wr(A_KEY, 32'h0000_5555);
    rd_exp(A_KEY, 32'd0, "R3 stopped");
    cyc(1, 0, A_CNT, 32'd0, 0);
    held = rsp_data;
    idle(8, 1);
    rd_exp(A_CNT, held, "R5 hold after stop");

    // R9 unmapped
    wr(A_NONE, 32'h1234_5678);
    rd_exp(A_NONE, 32'd0, "R9 unmapped read");
    rd_exp(A_LD, 32'hFFFF_FFF0, "R9 unmapped write ignored");

    // random phase
    for (int n = 0; n < 30000; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1: a = A_CNT;
        2:    a = A_LD;
        3, 4, 5: a = A_KEY;
        6:    a = A_FLG;
        7:    a = A_NONE;
        default: a = A_KEY;
      endcase
      if (a == A_KEY) begin
        case ($urandom_range(0, 4))
          0: d = 32'h0000_AAAA;
          1: d = 32'h0000_5555;
          2: d = 32'h0000_BBBB;
          3: d = 32'h0000_4444;
          default: d = $urandom;
        endcase
      end else if (a == A_CNT || a == A_LD) begin
        d = 32'hFFFF_FF00 | ($urandom & 32'hFF);
      end else begin
        d = $urandom;
      end
      cyc(($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1, a, d,
          $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule